// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block is the coherence controller of one processor's private write-back cache. The cache is direct mapped and holds one data word per line. Each line carries one of four coherence states: Modified, Exclusive, Shared or Invalid. The processor side takes one read or write at a time and holds it until a completion pulse. The bus side attaches to a shared, atomic snooping bus. An external arbiter grants that bus with a simple grant signal.

When the controller needs the bus, it raises a request that carries a command: read for sharing, read for ownership, or write-back of a dirty victim. It then waits for the grant. A fixed number of cycles after the address cycle comes the snoop-response cycle. In that cycle the controller samples the wired-OR shared signal and the returned data word. The same response timing applies to the snoop port, which watches the commands of the other masters. In the response cycle the controller drives its shared vote. When it owns the only up-to-date copy it also drives a flush strobe with the data. That strobe tells memory to stay silent so that the cache supplies the word instead.

The clean-exclusive state is chosen on a read miss when no other cache votes shared. A later write to such a line then becomes a local upgrade that does not touch the bus.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid. cpuDone, mReq, snShared and snFlush are all low.
- R2: A processor read that hits a line in Modified, Exclusive or Shared raises no bus request. cpuDone pulses for one cycle in the cycle after the one in which the request is first seen, and cpuRdata then holds the line's word.
- R3: A processor read that misses requests the bus with mCmd = 1 (read for sharing) and mAddr = cpuAddr. The response cycle comes RESP_DLY cycles after the granted address cycle. busShared low in that cycle installs the line as Exclusive; busShared high installs it as Shared. The line takes busData, and cpuDone follows one cycle after the response cycle.
- R4: A processor write to an Exclusive line changes it to Modified with no bus request and finishes like a hit.
- R5: A processor write to a Shared or Invalid line requests the bus with mCmd = 2 (read for ownership). The line ends Modified and holds the written word.
- R6: A snooped read for sharing (snCmd = 1) that matches a valid line drives snShared high in the cycle RESP_DLY after the snoop address cycle, and low before it. A Modified line also flushes its word on snFlushData and becomes Shared. An Exclusive line becomes Shared. A Shared line stays Shared.
- R7: A snooped read for ownership (snCmd = 2) that matches a valid line drives snShared in the response cycle and leaves the line Invalid. A Modified line also flushes its word.
- R8: A snoop whose address matches no valid line raises neither snShared nor snFlush and leaves every line unchanged, including a valid line at the same index with a different tag.
- R9: A miss whose line holds a Modified block with another tag first requests mCmd = 3 (write-back). It presents the victim's address and word on mAddr and mWdata, and only then issues the fill.
- R10: A miss whose line holds a Shared or Exclusive block with another tag replaces it with no write-back request.
- R11: snFlush is raised only for a line that was Modified, and never without snShared.
- R12: Once raised, mReq stays high until mGnt is seen, and it always carries a non-zero command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until cpuDone |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Write word |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read word, valid with cpuDone |
| mReq | output | 1 | Bus request |
| mGnt | input | 1 | Bus grant; high marks the address cycle |
| mCmd | output | 2 | 1 read for sharing, 2 read for ownership, 3 write-back |
| mAddr | output | ADDR_W | Address of the requested transaction |
| mWdata | output | DATA_W | Victim word for a write-back |
| busShared | input | 1 | Wired-OR shared vote, sampled in the response cycle |
| busData | input | DATA_W | Fill word, sampled in the response cycle |
| snValid | input | 1 | Another master's address cycle is on the bus |
| snCmd | input | 2 | Snooped command: 1 read for sharing, 2 read for ownership |
| snAddr | input | ADDR_W | Snooped address |
| snShared | output | 1 | This cache's shared vote in the response cycle |
| snFlush | output | 1 | This cache supplies the word; memory must not respond |
| snFlushData | output | DATA_W | Flushed word |

## Verification
The bench builds the block with four lines, an 8-bit address and a 16-bit word. The response delay is two cycles, so a vote that shows up one cycle early can be told apart from one that arrives on time. With only four lines, two addresses that share an index are easy to find. That lets the bench fill an index with a dirty line, a clean exclusive line and a shared line in turn, and so reach both eviction paths. It also lets it aim a snoop at a different tag on an index that is already occupied. The bench holds back one grant for several cycles to show that the request is kept up and that the completion moves later by the same amount.

// File: rtl/mesi_ctl_pkg.sv
package mesi_ctl_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineSt_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_e;

  // strobes from the control FSM to the line store
  typedef struct packed {
    logic    setCpu;
    lineSt_e cpuNext;
    logic    fill;
    logic    wrData;
    logic    capRd;
    logic    setSnp;
    lineSt_e snpNext;
    logic    capFlush;
  } ctlStrb_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] busData,
  input  logic [ADDR_W-1:0] snAddr,
  output lineSt_e           cpuSt,
  output lineSt_e           vicSt,
  output logic [ADDR_W-1:0] vicAddr,
  output logic [DATA_W-1:0] lineData,
  output lineSt_e           snSt,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] flushData
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineSt_e           stArr  [NUM_LINES];
  logic [TAG_W-1:0]  tagArr [NUM_LINES];
  logic [DATA_W-1:0] datArr [NUM_LINES];

  logic [IDX_W-1:0] cpuIdx, snIdx;
  logic [TAG_W-1:0] cpuTag, snTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snIdx  = snAddr[IDX_W-1:0];
  assign snTag  = snAddr[ADDR_W-1:IDX_W];

  // a tag mismatch reads as Invalid
  assign cpuSt    = (tagArr[cpuIdx] == cpuTag) ? stArr[cpuIdx] : LS_I;
  assign snSt     = (tagArr[snIdx] == snTag) ? stArr[snIdx] : LS_I;
  assign vicSt    = stArr[cpuIdx];
  assign vicAddr  = {tagArr[cpuIdx], cpuIdx};
  assign lineData = datArr[cpuIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) stArr[i] <= LS_I;
    end else begin
      if (strb.setSnp) stArr[snIdx] <= strb.snpNext;
      if (strb.setCpu) stArr[cpuIdx] <= strb.cpuNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill) tagArr[cpuIdx] <= cpuTag;
    if (strb.fill || strb.wrData) datArr[cpuIdx] <= cpuWe ? cpuWdata : busData;
    if (strb.capRd) rdData <= strb.fill ? busData : datArr[cpuIdx];
    if (strb.capFlush) flushData <= datArr[snIdx];
  end

endmodule

// File: rtl/mesi_ctl_fsm.sv
module mesi_ctl_fsm
  import mesi_ctl_pkg::*;
#(
  parameter int RESP_DLY = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     cpuWe,
  input  lineSt_e  cpuSt,
  input  lineSt_e  vicSt,
  input  logic     mGnt,
  input  logic     busShared,
  input  logic     snValid,
  input  logic [1:0] snCmd,
  input  lineSt_e  snSt,
  output ctlStrb_t strb,
  output logic     cpuDone,
  output logic     mReq,
  output busCmd_e  mCmd,
  output logic     snShared,
  output logic     snFlush
);

  localparam int CNT_W = (RESP_DLY > 1) ? $clog2(RESP_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESP_DLY - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_DONE} fsm_e;

  fsm_e fsm, fsmNext;
  logic [CNT_W-1:0] waitCnt, respCnt;
  logic respPend, respShr, respFls;
  logic needBus, dirtyVictim, snMatch;
  busCmd_e reqCmd;

  assign needBus     = (cpuSt == LS_I) || (cpuWe && cpuSt == LS_S);
  assign dirtyVictim = (cpuSt == LS_I) && (vicSt == LS_M);
  assign reqCmd      = dirtyVictim ? BC_WB : (cpuWe ? BC_RDX : BC_RD);
  assign snMatch     = snValid && (snSt != LS_I) &&
                       (snCmd == BC_RD || snCmd == BC_RDX);

  assign mReq    = (fsm == F_REQ);
  assign mCmd    = mReq ? reqCmd : BC_NONE;
  assign cpuDone = (fsm == F_DONE);

  always_comb begin
    strb     = '0;
    fsmNext  = fsm;
    // snoop side
    strb.setSnp   = snMatch;
    strb.snpNext  = (snCmd == BC_RDX) ? LS_I : LS_S;
    strb.capFlush = snMatch && (snSt == LS_M);
    // processor side
    unique case (fsm)
      F_IDLE: if (cpuReq && !snValid) begin
        if (!needBus) begin
          fsmNext      = F_DONE;
          strb.capRd   = !cpuWe;
          strb.wrData  = cpuWe;
          strb.setCpu  = cpuWe;
          strb.cpuNext = LS_M;
        end else begin
          fsmNext = F_REQ;
        end
      end
      F_REQ: if (mGnt) begin
        if (reqCmd == BC_WB) begin
          fsmNext      = F_IDLE;
          strb.setCpu  = 1'b1;
          strb.cpuNext = LS_I;
        end else begin
          fsmNext = F_WAIT;
        end
      end
      F_WAIT: if (waitCnt == '0) begin
        fsmNext      = F_DONE;
        strb.fill    = 1'b1;
        strb.capRd   = !cpuWe;
        strb.setCpu  = 1'b1;
        strb.cpuNext = cpuWe ? LS_M : (busShared ? LS_S : LS_E);
      end
      F_DONE: fsmNext = F_IDLE;
      default: fsmNext = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm     <= F_IDLE;
      waitCnt <= '0;
    end else begin
      fsm <= fsmNext;
      if (fsm == F_REQ && mGnt) waitCnt <= CNT_LOAD;
      else if (fsm == F_WAIT && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
    end
  end

  // snoop response lands RESP_DLY cycles after the snooped address cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respPend <= 1'b0;
      respCnt  <= '0;
      respShr  <= 1'b0;
      respFls  <= 1'b0;
    end else if (snValid) begin
      respPend <= 1'b1;
      respCnt  <= CNT_LOAD;
      respShr  <= snMatch;
      respFls  <= snMatch && (snSt == LS_M);
    end else if (respPend) begin
      if (respCnt == '0) respPend <= 1'b0;
      else respCnt <= respCnt - 1'b1;
    end
  end

  assign snShared = respPend && (respCnt == '0) && respShr;
  assign snFlush  = respPend && (respCnt == '0) && respFls;

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import mesi_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4,
  parameter int RESP_DLY  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              mReq,
  input  logic              mGnt,
  output logic [1:0]        mCmd,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic              busShared,
  input  logic [DATA_W-1:0] busData,
  input  logic              snValid,
  input  logic [1:0]        snCmd,
  input  logic [ADDR_W-1:0] snAddr,
  output logic              snShared,
  output logic              snFlush,
  output logic [DATA_W-1:0] snFlushData
);

  ctlStrb_t          strb;
  lineSt_e           cpuSt, vicSt, snSt;
  busCmd_e           cmd;
  logic [ADDR_W-1:0] vicAddr;

  mesi_line_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuWe(cpuWe),
    .busData(busData), .snAddr(snAddr),
    .cpuSt(cpuSt), .vicSt(vicSt), .vicAddr(vicAddr), .lineData(mWdata),
    .snSt(snSt), .rdData(cpuRdata), .flushData(snFlushData)
  );

  mesi_ctl_fsm #(.RESP_DLY(RESP_DLY)) u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuSt(cpuSt), .vicSt(vicSt), .mGnt(mGnt), .busShared(busShared),
    .snValid(snValid), .snCmd(snCmd), .snSt(snSt), .strb(strb),
    .cpuDone(cpuDone), .mReq(mReq), .mCmd(cmd),
    .snShared(snShared), .snFlush(snFlush)
  );

  assign mCmd  = cmd;
  assign mAddr = (cmd == BC_WB) ? vicAddr : cpuAddr;

endmodule

// File: rtl/mesi_snoop_cache_chk.sv
module mesi_snoop_cache_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuDone,
  input logic       mReq,
  input logic       mGnt,
  input logic [1:0] mCmd,
  input logic       snShared,
  input logic       snFlush
);

  // R11: supplying data implies holding the block
  p_flush_has_vote_r11: assert property (@(posedge clk) disable iff (!rstN)
    snFlush |-> snShared);

  // R12: request kept up until granted
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    mReq && !mGnt |=> mReq);

  // R12: a request always names a command
  p_req_has_cmd_r12: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> mCmd != 2'd0);

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  // R9: no completion while a bus transaction is still pending
  p_no_done_in_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> !cpuDone);

  // R3: a granted fill leaves the request line quiet in the next cycle
  p_fill_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    mReq && mGnt && mCmd != 2'd3 |=> !mReq);

endmodule

bind mesi_snoop_cache mesi_snoop_cache_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuDone(cpuDone), .mReq(mReq), .mGnt(mGnt),
  .mCmd(mCmd), .snShared(snShared), .snFlush(snFlush)
);

// File: tb/sim_mesi_snoop_cache.sv
module sim_mesi_snoop_cache;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int RESP_DLY = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuDone;
  logic [DW-1:0] cpuRdata;
  logic mReq, mGnt = 1'b0;
  logic [1:0] mCmd;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mWdata;
  logic busShared = 1'b0;
  logic [DW-1:0] busData = '0;
  logic snValid = 1'b0;
  logic [1:0] snCmd = '0;
  logic [AW-1:0] snAddr = '0;
  logic snShared, snFlush;
  logic [DW-1:0] snFlushData;

  always #10 clk = ~clk;

  mesi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(4), .RESP_DLY(RESP_DLY)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .mReq(mReq), .mGnt(mGnt), .mCmd(mCmd), .mAddr(mAddr), .mWdata(mWdata),
    .busShared(busShared), .busData(busData), .snValid(snValid),
    .snCmd(snCmd), .snAddr(snAddr), .snShared(snShared), .snFlush(snFlush),
    .snFlushData(snFlushData)
  );

  int nChecks = 0;
  int nFails = 0;

  // transaction log of the last processor access
  int nTx;
  logic [1:0] txCmd [4];
  logic [AW-1:0] txAddr [4];
  logic [DW-1:0] txDat [4];
  int doneLat;
  logic [DW-1:0] rdVal;
  logic reqDropped;

  // snoop results
  logic sSh, sFl, sEarly;
  logic [DW-1:0] sDat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // processor access with a bus model granting after gDly waiting cycles
  task automatic cpuRun(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic shr, input logic [DW-1:0] fill, input int gDly);
    int respCnt;
    int waitG;
    nTx = 0; doneLat = 0; respCnt = 0; waitG = 0; reqDropped = 1'b0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    for (int cyc = 1; cyc < 60; cyc++) begin
      @(negedge clk);
      mGnt = 1'b0; busShared = 1'b0; busData = '0;
      if (cpuDone) begin
        doneLat = cyc; rdVal = cpuRdata;
        break;
      end
      if (respCnt > 0) begin
        respCnt--;
        if (respCnt == 0) begin busShared = shr; busData = fill; end
      end else if (mReq) begin
        if (waitG < gDly) waitG++;
        else begin
          mGnt = 1'b1;
          if (nTx < 4) begin
            txCmd[nTx] = mCmd; txAddr[nTx] = mAddr; txDat[nTx] = mWdata;
          end
          nTx++;
          if (mCmd != 2'd3) respCnt = RESP_DLY;
          waitG = 0;
        end
      end else if (waitG > 0) reqDropped = 1'b1;
    end
    cpuReq = 1'b0; cpuWe = 1'b0;
    if (doneLat == 0) chk("watchdog cpu access never completed", 0, 1);
  endtask

  task automatic snoopRun(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    snValid = 1'b1; snCmd = c; snAddr = a;
    sEarly = 1'b0;
    for (int k = 1; k <= RESP_DLY; k++) begin
      @(negedge clk);
      snValid = 1'b0; snCmd = '0;
      if (k < RESP_DLY) sEarly = sEarly | snShared | snFlush;
      else begin sSh = snShared; sFl = snFlush; sDat = snFlushData; end
    end
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk("R1 cpuDone at reset", cpuDone, 0);
    chk("R1 mReq at reset", mReq, 0);
    chk("R1 snShared at reset", snShared, 0);
    chk("R1 snFlush at reset", snFlush, 0);
    rstN = 1'b1;
  endtask

  task automatic tReadMissExcl();
    cpuRun(0, 8'h10, 0, 0, 16'hA1A1, 3);
    chk("R1 cold line misses", nTx, 1);
    chk("R3 read miss cmd", txCmd[0], 1);
    chk("R3 read miss addr", txAddr[0], 8'h10);
    chk("R3 fill data", rdVal, 16'hA1A1);
    chk("R12 latency with held grant", doneLat, 3 + RESP_DLY + 2);
    chk("R12 request not dropped", reqDropped, 0);
    cpuRun(0, 8'h10, 0, 0, 0, 0);
    chk("R2 hit E no bus", nTx, 0);
    chk("R2 hit latency", doneLat, 1);
    chk("R2 hit data", rdVal, 16'hA1A1);
  endtask

  task automatic tSilentUpgrade();
    cpuRun(1, 8'h10, 16'h5555, 0, 0, 0);
    chk("R4 write E silent", nTx, 0);
    chk("R4 write E latency", doneLat, 1);
    cpuRun(0, 8'h10, 0, 0, 0, 0);
    chk("R2 hit M no bus", nTx, 0);
    chk("R2 hit M data", rdVal, 16'h5555);
  endtask

  task automatic tSnoopRdOnModified();
    snoopRun(1, 8'h10);
    chk("R6 vote not early", sEarly, 0);
    chk("R6 shared on M", sSh, 1);
    chk("R11 flush on M", sFl, 1);
    chk("R6 flush data", sDat, 16'h5555);
    snoopRun(1, 8'h10);
    chk("R6 now S shared", sSh, 1);
    chk("R11 S does not flush", sFl, 0);
    cpuRun(1, 8'h10, 16'h6666, 0, 16'hDEAD, 0);
    chk("R5 write S txn count", nTx, 1);
    chk("R5 write S cmd", txCmd[0], 2);
    chk("R5 write S addr", txAddr[0], 8'h10);
    chk("R5 write S latency", doneLat, RESP_DLY + 2);
    cpuRun(0, 8'h10, 0, 0, 0, 0);
    chk("R5 written word kept", rdVal, 16'h6666);
    chk("R5 line now owned", nTx, 0);
  endtask

  task automatic tSnoopRdxOnModified();
    snoopRun(2, 8'h10);
    chk("R7 rdx on M shared", sSh, 1);
    chk("R7 rdx on M flush", sFl, 1);
    chk("R7 rdx flush data", sDat, 16'h6666);
    snoopRun(1, 8'h10);
    chk("R7 line invalid no vote", sSh, 0);
    chk("R7 line invalid no flush", sFl, 0);
    cpuRun(0, 8'h10, 0, 0, 16'h1234, 0);
    chk("R7 invalid line misses", nTx, 1);
  endtask

  task automatic tReadMissShared();
    cpuRun(0, 8'h21, 0, 1, 16'hBEEF, 0);
    chk("R3 shared fill cmd", txCmd[0], 1);
    chk("R3 shared fill data", rdVal, 16'hBEEF);
    cpuRun(0, 8'h21, 0, 0, 0, 0);
    chk("R2 hit S no bus", nTx, 0);
    snoopRun(1, 8'h21);
    chk("R6 S stays shared", sSh, 1);
    chk("R6 S no flush", sFl, 0);
    cpuRun(1, 8'h21, 16'h7777, 0, 0, 0);
    chk("R3 vote gave S so write upgrades", txCmd[0], 2);
  endtask

  task automatic tEvictDirty();
    cpuRun(0, 8'h25, 0, 0, 16'h0C0C, 0);
    chk("R9 two transactions", nTx, 2);
    chk("R9 write-back first", txCmd[0], 3);
    chk("R9 victim addr", txAddr[0], 8'h21);
    chk("R9 victim data", txDat[0], 16'h7777);
    chk("R9 then fill", txCmd[1], 1);
    chk("R9 fill addr", txAddr[1], 8'h25);
    chk("R9 fill data", rdVal, 16'h0C0C);
    snoopRun(1, 8'h21);
    chk("R9 victim gone", sSh, 0);
  endtask

  task automatic tEvictClean();
    cpuRun(0, 8'h29, 0, 1, 16'h2929, 0);
    chk("R10 E victim no write-back", nTx, 1);
    chk("R10 E victim fill cmd", txCmd[0], 1);
    cpuRun(0, 8'h2D, 0, 0, 16'h2D2D, 0);
    chk("R10 S victim no write-back", nTx, 1);
    chk("R10 S victim fill addr", txAddr[0], 8'h2D);
  endtask

  task automatic tSnoopRdxOnExcl();
    snoopRun(2, 8'h2D);
    chk("R7 rdx on E shared", sSh, 1);
    chk("R7 rdx on E no flush", sFl, 0);
    cpuRun(1, 8'h2D, 16'h4444, 0, 0, 0);
    chk("R7 E invalidated so write needs bus", txCmd[0], 2);
    snoopRun(1, 8'h2D);
    chk("R11 M flushes", sFl, 1);
    chk("R6 M flush data", sDat, 16'h4444);
  endtask

  task automatic tNoMatch();
    snoopRun(2, 8'h14);
    chk("R8 other tag no vote", sSh, 0);
    chk("R8 other tag no flush", sFl, 0);
    cpuRun(0, 8'h10, 0, 0, 0, 0);
    chk("R8 line still hits", nTx, 0);
    chk("R8 data intact", rdVal, 16'h1234);
    cpuRun(1, 8'h10, 16'h9999, 0, 0, 0);
    chk("R8 line still E silent write", nTx, 0);
  endtask

  task automatic tWriteMiss();
    cpuRun(1, 8'h42, 16'hABCD, 1, 16'h0000, 0);
    chk("R5 write miss cmd", txCmd[0], 2);
    chk("R5 write miss addr", txAddr[0], 8'h42);
    cpuRun(0, 8'h42, 0, 0, 0, 0);
    chk("R5 write miss data", rdVal, 16'hABCD);
    chk("R5 write miss owned", nTx, 0);
  endtask

  initial begin
    tReset();
    tReadMissExcl();
    tSilentUpgrade();
    tSnoopRdOnModified();
    tSnoopRdxOnModified();
    tReadMissShared();
    tEvictDirty();
    tEvictClean();
    tSnoopRdxOnExcl();
    tNoMatch();
    tWriteMiss();
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule